// File: doc/BRIEF.md
# Per-Pin Digital Glitch Filter Bank

This block cleans up a group of slow digital inputs before the rest of the chip sees them. Every pin has its own filter. A filter's output moves to a new level only once the raw input has held that level for more than a programmed number of filter clock periods. Shorter excursions never reach the output. All pins share a single width setting and a single choice of filter clock. Each pin has its own enable bit.

The filter clock is either every cycle of the bus clock or a slow tick input. The slow tick is a one-cycle-wide clock enable that stands in for a low-power millisecond time base. A disabled filter drives zero and forgets any count in progress. Software programs the block through a plain single-cycle write port with a combinational read path. The clock choice and the width are meant to change only while every filter is disabled.

Top module: `glitch_filter_bank`

## Requirements
- R1: After reset every filtered output is 0, and the enable, clock-select and width registers all read 0.
- R2: A write with `reg_we` high takes effect at that clock edge and can be read back. The enable register is at 0xC0, and its bit i enables pin i. The clock select is bit 0 at 0xC4. The width is bits 4:0 at 0xC8.
- R3: An enabled pin whose input differs from its output for W+1 consecutive filter clocks (W = width) takes the input level at the (W+1)th filter clock. Each pin behaves independently of the others.
- R4: An input pulse that lasts W filter clocks or fewer leaves the output unchanged.
- R5: If the input returns to the output level before the count passes W, the count restarts from zero. Two short pulses separated by one clock therefore do not combine.
- R6: With W = 0 and the bus clock selected, an enabled output equals the input as sampled one clock earlier.
- R7: When a pin's enable bit is 0, its output is 0 one clock later and stays 0 whatever the input does. After re-enabling, the filter starts counting from zero.
- R8: Clock select 0 advances the filters on every bus clock. Clock select 1 advances them only on clocks where `slow_tick` is 1, and outputs hold on every other clock.
- R9: Unimplemented register bits read 0. Any other address reads 0, and writes to other addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pin_in | input | 32 | Raw pin levels |
| slow_tick | input | 1 | Slow time-base clock enable |
| pin_filt | output | 32 | Filtered pin levels |

## Verification
The hardest case to reach from the ports is a filter count that has been paused part way: the slow tick is selected, the input has already changed, and some bus clocks pass with the tick low. The stimulus selects the slow tick and raises a pin. It then gives single tick pulses with idle bus clocks between them, checking after each pulse that the output holds until the third pulse at width 2. A second case is a pulse broken by a one-clock return to the old level, which shows whether the count restarts. A third is clearing one enable bit while its input stays high.

// File: rtl/glitch_filt_pkg.sv
package glitch_filt_pkg;

    // Register byte offsets; the software view depends on these values.
    localparam int OFS_ENABLE = 'hC0;
    localparam int OFS_CLKSEL = 'hC4;
    localparam int OFS_WIDTH  = 'hC8;

    // Filter time base
    typedef enum logic {
        CLK_BUS  = 1'b0,
        CLK_SLOW = 1'b1
    } clk_src_e;

endpackage

// File: rtl/glitch_filt_regs.sv
module glitch_filt_regs
    import glitch_filt_pkg::*;
#(
    parameter int NUM_PINS   = 32,
    parameter int WIDTH_BITS = 5,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic [NUM_PINS-1:0]   en_vec,
    output clk_src_e              clk_sel,
    output logic [WIDTH_BITS-1:0] filt_width
);

    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(OFS_CLKSEL);
    localparam logic [ADDR_W-1:0] A_WID = ADDR_W'(OFS_WIDTH);

    typedef struct packed {
        logic [NUM_PINS-1:0]   en;
        clk_src_e              sel;
        logic [WIDTH_BITS-1:0] width;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    // Next-state: single-cycle writes
    always_comb begin
        cfg_d = cfg_q;
        if (reg_we) begin
            unique case (reg_addr)
                A_EN:    cfg_d.en    = reg_wdata[NUM_PINS-1:0];
                A_SEL:   cfg_d.sel   = clk_src_e'(reg_wdata[0]);
                A_WID:   cfg_d.width = reg_wdata[WIDTH_BITS-1:0];
                default: cfg_d       = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{en: '0, sel: CLK_BUS, width: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // Read path, zero-extended
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_EN:    reg_rdata[NUM_PINS-1:0]   = cfg_q.en;
            A_SEL:   reg_rdata[0]              = cfg_q.sel;
            A_WID:   reg_rdata[WIDTH_BITS-1:0] = cfg_q.width;
            default: reg_rdata                 = '0;
        endcase
    end

    assign en_vec     = cfg_q.en;
    assign clk_sel    = cfg_q.sel;
    assign filt_width = cfg_q.width;

endmodule

// File: rtl/glitch_filt_step.sv
module glitch_filt_step
    import glitch_filt_pkg::*;
(
    input  clk_src_e clk_sel,
    input  logic     slow_tick,
    output logic     step
);

    // Filter clock enable: every bus cycle, or only when the slow tick is high
    always_comb begin
        unique case (clk_sel)
            CLK_SLOW: step = slow_tick;
            default:  step = 1'b1;
        endcase
    end

endmodule

// File: rtl/glitch_filt_cell.sv
module glitch_filt_cell #(
    parameter int WIDTH_BITS = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  step,
    input  logic [WIDTH_BITS-1:0] width,
    input  logic                  din,
    output logic                  dout
);

    typedef struct packed {
        logic                  level;
        logic [WIDTH_BITS-1:0] run;
    } cell_t;

    cell_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d = '0;
        end else if (step) begin
            if (din == st_q.level) begin
                st_d.run = '0;
            end else if (st_q.run >= width) begin
                st_d.level = din;
                st_d.run   = '0;
            end else begin
                st_d.run = st_q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.level;

endmodule

// File: rtl/glitch_filter_bank.sv
module glitch_filter_bank
    import glitch_filt_pkg::*;
#(
    parameter int NUM_PINS   = 32,
    parameter int WIDTH_BITS = 5,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                slow_tick,
    output logic [NUM_PINS-1:0] pin_filt
);

    logic [NUM_PINS-1:0]   en_vec;
    clk_src_e              clk_sel;
    logic [WIDTH_BITS-1:0] filt_width;
    logic                  step;

    glitch_filt_regs #(
        .NUM_PINS  (NUM_PINS),
        .WIDTH_BITS(WIDTH_BITS),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .en_vec    (en_vec),
        .clk_sel   (clk_sel),
        .filt_width(filt_width)
    );

    glitch_filt_step step_i (
        .clk_sel  (clk_sel),
        .slow_tick(slow_tick),
        .step     (step)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        glitch_filt_cell #(
            .WIDTH_BITS(WIDTH_BITS)
        ) cell_i (
            .clk   (clk),
            .rst_n (rst_n),
            .enable(en_vec[g]),
            .step  (step),
            .width (filt_width),
            .din   (pin_in[g]),
            .dout  (pin_filt[g])
        );
    end

endmodule

// File: rtl/glitch_filter_bank_chk.sv
module glitch_filter_bank_chk
    import glitch_filt_pkg::*;
#(
    parameter int N      = 32,
    parameter int WBITS  = 5,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [WBITS-1:0]  wdata_lo,
    input logic [N-1:0]      pin_in,
    input logic              slow_tick,
    input logic [N-1:0]      pin_filt,
    input logic [N-1:0]      en_vec,
    input logic              clk_sel,
    input logic [WBITS-1:0]  filt_width
);

    // R7: a pin disabled at an edge reads zero after it
    p_disabled_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (~en_vec != '0) |=> ((pin_filt & ~$past(en_vec)) == '0));

    // R3: an enabled output only ever moves to the level its input had
    p_change_matches_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|en_vec) |=> (((pin_filt ^ $past(pin_filt)) & $past(en_vec)
                        & (pin_filt ^ $past(pin_in))) == '0));

    // R6: zero width on the bus clock tracks the input one clock later
    p_zero_width_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_width == '0 && clk_sel == 1'b0)
        |=> (((pin_filt ^ $past(pin_in)) & $past(en_vec)) == '0));

    // R8: on the slow time base, no tick means no output change
    p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel && !slow_tick)
        |=> ((pin_filt & $past(en_vec)) == ($past(pin_filt) & $past(en_vec))));

    // R2: a width write lands in the next cycle
    p_width_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(OFS_WIDTH)) |=> (filt_width == $past(wdata_lo)));

endmodule

bind glitch_filter_bank glitch_filter_bank_chk #(
    .N     (NUM_PINS),
    .WBITS (WIDTH_BITS),
    .ADDR_W(ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .wdata_lo  (reg_wdata[WIDTH_BITS-1:0]),
    .pin_in    (pin_in),
    .slow_tick (slow_tick),
    .pin_filt  (pin_filt),
    .en_vec    (en_vec),
    .clk_sel   (clk_sel),
    .filt_width(filt_width)
);

// File: tb/glitch_filter_bank_tb_top.sv
module glitch_filter_bank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 32;
    localparam logic [7:0] A_EN  = 8'hC0;
    localparam logic [7:0] A_SEL = 8'hC4;
    localparam logic [7:0] A_WID = 8'hC8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] pin_in = '0;
    logic          slow_tick = 1'b0;
    logic [NP-1:0] pin_filt;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    typedef struct {
        int          c;
        logic [31:0] v;
        string       tag;
    } exp_t;
    exp_t sb[$];

    glitch_filter_bank dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .pin_in   (pin_in),
        .slow_tick(slow_tick),
        .pin_filt (pin_filt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc = cyc + 1;

    // Monitor: compare queued expectations at their scheduled negedge
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].c <= cyc) begin
                n_checks++;
                if (pin_filt !== sb[i].v) begin
                    n_fail++;
                    $display("FAIL %s: pin_filt=%h expected %h (cycle %0d)",
                             sb[i].tag, pin_filt, sb[i].v, cyc);
                end
                sb.delete(i);
            end
        end
    end

    task automatic expect_at(input int k, input logic [31:0] v, input string tag);
        sb.push_back('{c: cyc + k, v: v, tag: tag});
    endtask

    task automatic step_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
        reg_addr = a;
        #1;
        n_checks++;
        if (reg_rdata !== e) begin
            n_fail++;
            $display("FAIL %s: rdata[%h]=%h expected %h", tag, a, reg_rdata, e);
        end
    endtask

    task automatic tick_once();
        slow_tick = 1'b1;
        @(negedge clk);
        slow_tick = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail + 1, n_checks + 1);
        $finish;
    end

    initial begin
        step_n(3);
        rst_n = 1'b1;
        step_n(1);

        // R1: reset state
        rd_chk(A_EN,  32'h0, "R1");
        rd_chk(A_SEL, 32'h0, "R1");
        rd_chk(A_WID, 32'h0, "R1");
        expect_at(1, 32'h0, "R1");
        step_n(2);

        // R2: program width 3 on the bus clock, enable all pins
        wr(A_WID, 32'd3);
        wr(A_SEL, 32'd0);
        wr(A_EN,  32'hFFFF_FFFF);
        rd_chk(A_WID, 32'd3, "R2");
        rd_chk(A_EN,  32'hFFFF_FFFF, "R2");
        step_n(2);

        // R4: 3-clock pulse on pin 0 with width 3 is absorbed
        pin_in = 32'h1;
        for (int k = 1; k <= 6; k++) expect_at(k, 32'h0, "R4");
        step_n(3);
        pin_in = 32'h0;
        step_n(5);

        // R3: 4-clock pulse on pin 1 passes, rising and falling after 4 clocks (R8 bus mode)
        pin_in = 32'h2;
        expect_at(3, 32'h0, "R3");
        expect_at(4, 32'h2, "R3");
        step_n(4);
        pin_in = 32'h0;
        expect_at(3, 32'h2, "R3");
        expect_at(4, 32'h0, "R8");
        step_n(6);

        // R5: two 3-clock pulses split by one low clock never combine
        pin_in = 32'h4;
        for (int k = 1; k <= 10; k++) expect_at(k, 32'h0, "R5");
        step_n(3);
        pin_in = 32'h0;
        step_n(1);
        pin_in = 32'h4;
        step_n(3);
        pin_in = 32'h0;
        step_n(5);

        // R3: independent pins, short on pin 6, long on pin 5
        pin_in = 32'h60;
        expect_at(3, 32'h0, "R3");
        expect_at(4, 32'h20, "R3");
        step_n(2);
        pin_in = 32'h20;
        step_n(4);
        pin_in = 32'h0;
        expect_at(3, 32'h20, "R3");
        expect_at(4, 32'h0, "R3");
        step_n(5);

        // R7: disabling a high output forces zero, re-enable restarts count
        pin_in = 32'h100;
        expect_at(4, 32'h100, "R7");
        step_n(5);
        wr(A_EN, ~32'h100);
        for (int k = 1; k <= 4; k++) expect_at(k, 32'h0, "R7");
        step_n(4);
        wr(A_EN, 32'hFFFF_FFFF);
        expect_at(3, 32'h0, "R7");
        expect_at(4, 32'h100, "R7");
        step_n(5);
        pin_in = 32'h0;
        expect_at(4, 32'h0, "R7");
        step_n(6);

        // R6: width 0 follows input one clock later
        wr(A_EN, 32'h0);
        wr(A_WID, 32'd0);
        wr(A_EN, 32'hFFFF_FFFF);
        pin_in = 32'hA5A5_00FF;
        expect_at(1, 32'hA5A5_00FF, "R6");
        step_n(1);
        pin_in = 32'h5A5A_FF00;
        expect_at(1, 32'h5A5A_FF00, "R6");
        step_n(1);
        pin_in = 32'h0;
        expect_at(1, 32'h0, "R6");
        step_n(2);

        // R8: slow tick, width 2, output moves on the third tick only
        wr(A_EN, 32'h0);
        wr(A_SEL, 32'd1);
        wr(A_WID, 32'd2);
        wr(A_EN, 32'hFFFF_FFFF);
        rd_chk(A_SEL, 32'd1, "R2");
        pin_in = 32'h1;
        for (int k = 1; k <= 5; k++) expect_at(k, 32'h0, "R8");
        step_n(5);
        tick_once();
        expect_at(1, 32'h0, "R8");
        step_n(2);
        tick_once();
        expect_at(1, 32'h0, "R8");
        step_n(2);
        tick_once();
        expect_at(1, 32'h1, "R8");
        step_n(2);
        pin_in = 32'h0;
        for (int k = 1; k <= 4; k++) expect_at(k, 32'h1, "R8");
        step_n(4);
        tick_once();
        tick_once();
        expect_at(1, 32'h1, "R8");
        step_n(1);
        tick_once();
        expect_at(1, 32'h0, "R8");
        step_n(2);

        // R9: field clipping and unmapped addresses
        wr(A_EN, 32'h0);
        wr(A_WID, 32'hFFFF_FFFF);
        wr(A_SEL, 32'hFFFF_FFFE);
        rd_chk(A_WID, 32'h1F, "R9");
        rd_chk(A_SEL, 32'h0, "R9");
        wr(A_SEL, 32'hFFFF_FFFF);
        rd_chk(A_SEL, 32'h1, "R9");
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'hC1, 32'h0);
        rd_chk(8'h10, 32'h0, "R9");
        rd_chk(A_EN,  32'h0, "R9");
        rd_chk(A_WID, 32'h1F, "R9");
        rd_chk(A_SEL, 32'h1, "R9");

        while (sb.size() != 0) @(negedge clk);
        step_n(1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule